// File: doc/BRIEF.md
# Multi-Channel Serial Audio Port

This block is a free-running serial audio transmitter and receiver for a core-clock-synchronous system. Every 1024 core clocks it completes one sample frame of 64 bit-clock periods. It generates the bit clock and the word-select line, shifts out two stereo data lines (four channels) in 32-bit slots carrying up to 20-bit samples, and shifts in one stereo line of 16-bit samples. A single configuration input chooses between I2S framing and right-justified framing. The choice applies to both directions and takes effect at frame boundaries only.

Samples to send arrive on a valid/ready stream. One transfer carries all four channel words. The block keeps one set in a holding register. At each frame boundary it moves that set into the lanes, so an accepted set goes out in the frame after the boundary that follows the transfer. Back-pressure rules: `s_ready` is high exactly while the holding register is empty. A transfer happens on a clock edge where both `s_valid` and `s_ready` are high, and `s_ready` then stays low until the next frame boundary. If no set is held at a boundary, the following frame carries silence. Received samples leave on a one-cycle `m_valid` pulse once per frame, with no ready. The consumer must take them in that cycle, because the next words arrive one frame later.

DIV and 2*SLOT must be powers of two. OUT_W must not exceed SLOT-1.

Top module: `sap_serial_port`

## Requirements
- R1: While reset is held, `bclk`, `ws` and both `sdo` bits are 0, `s_ready` is 1 and `m_valid` is 0.
- R2: `bclk` has a period of 16 core clocks with 8 high and 8 low. One frame is 64 bit clocks. Bit k of a frame (k from 0) is the k-th rising edge of `bclk` counted modulo 64 from reset release.
- R3: `sdo` changes only together with a falling edge of `bclk`, and `ws` changes only together with a rising edge of `bclk`. Data is therefore stable for 8 core clocks on both sides of each rising edge.
- R4: I2S framing (`cfg_rj`=0): `ws` is 0 during bits 63 and 0..30 and 1 during bits 31..62. In slot s (bits 32*s..32*s+31, s=0 left, s=1 right), slot position p=1..20 carries sample bit 20-p, so the MSB is sent first.
- R5: Right-justified framing (`cfg_rj`=1): `ws` is 1 during bits 0..31 (left) and 0 during bits 32..63. Slot positions 12..31 carry sample bits 19..0, so the LSB lands in the last bit of the slot.
- R6: Every slot position outside the sample field is driven as 0 on both `sdo` lines.
- R7: `s_ready` is 1 exactly while no set is held. After a transfer, `s_ready` is 0 on the next cycle. A set accepted in frame F is sent in frame F+1. `s_data` packs lane 0 left in bits 19:0, lane 0 right in bits 39:20, lane 1 left in bits 59:40 and lane 1 right in bits 79:60. Lane n drives `sdo[n]`.
- R8: If no set is held at a frame boundary, the next frame carries all-zero data on both lanes.
- R9: `sdi` is sampled at the rising edge of `bclk`, MSB first, with 16-bit words. In I2S framing, slot positions 1..16 carry bits 15..0. In right-justified framing, positions 16..31 carry bits 15..0. Bits at all other positions are ignored.
- R10: `m_valid` is a one-cycle pulse, exactly once per frame. It is visible in the first core cycle of a frame and carries the words received in the frame that just ended.
- R11: `cfg_rj` is captured at frame boundaries only. A change in mid-frame leaves the rest of that frame's framing untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rj | input | 1 | 0 selects I2S framing, 1 selects right-justified framing |
| s_valid | input | 1 | Transmit sample set offered |
| s_ready | output | 1 | Holding register empty, a set can be taken |
| s_data | input | 80 | Four 20-bit channel words, packed as in R7 |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select |
| sdo | output | 2 | Serial data, one bit per stereo lane |
| sdi | input | 1 | Serial data input |
| m_valid | output | 1 | Received words valid, one-cycle pulse |
| m_left | output | 16 | Received left word |
| m_right | output | 16 | Received right word |

## Verification
The assertions take for granted that `sdi` and `cfg_rj` are synchronous to the core clock. They also assume that `s_data` is not changed while `s_valid` waits for `s_ready`. The stimulus drives every input one time unit after a falling core-clock edge. It sets `sdi` at each bit-clock fall, so the value is settled well before the rising edge where it is sampled. It fills unused receive positions with ones to expose any bit that should have been ignored. It flips `cfg_rj` in the middle of a frame, and it lets the transmit stream run dry so that silent frames appear.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  // True when slot position pos holds a sample bit for a w-bit word.
  function automatic logic in_field(fmt_e f, int pos, int w, int slot);
    if (f == FMT_I2S) return (pos >= 1) && (pos <= w);
    return pos >= (slot - w);
  endfunction

  // Sample bit number carried at slot position pos (valid only inside the field).
  function automatic int field_bit(fmt_e f, int pos, int w, int slot);
    if (f == FMT_I2S) return w - pos;
    return slot - 1 - pos;
  endfunction

endpackage

// File: rtl/sap_timing.sv
module sap_timing #(
  parameter int DIV  = 16,
  parameter int SLOT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        bclk_o,
  output logic [$clog2(2*SLOT)-1:0]   bit_idx_o,
  output logic [$clog2(2*SLOT)-1:0]   ws_idx_o,
  output logic                        sample_o,
  output logic                        last_o
);
  localparam int HALF  = DIV / 2;
  localparam int BITS  = 2 * SLOT;
  localparam int FRAME = BITS * DIV;
  localparam int CW    = $clog2(FRAME);
  localparam int PH_W  = $clog2(DIV);

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   ws_cnt;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (cnt == CW'(FRAME - 1))    cnt <= '0;
    else                               cnt <= cnt + CW'(1);
  end

  assign phase     = cnt[PH_W-1:0];
  assign bclk_o    = (phase >= PH_W'(HALF));
  assign bit_idx_o = cnt[CW-1:PH_W];
  // Word select runs half a bit clock behind data so it moves on bclk rise.
  assign ws_cnt    = (cnt >= CW'(HALF)) ? (cnt - CW'(HALF)) : (cnt + CW'(FRAME - HALF));
  assign ws_idx_o  = ws_cnt[CW-1:PH_W];
  assign sample_o  = (phase == PH_W'(HALF));
  assign last_o    = (cnt == CW'(FRAME - 1));

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
  import sap_pkg::*;
#(
  parameter int SLOT = 32,
  parameter int W    = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        fill_i,
  input  logic [2*W-1:0]              hold_i,
  input  fmt_e                        fmt_i,
  input  logic [$clog2(2*SLOT)-1:0]   bit_idx_i,
  output logic                        sdo_o
);
  localparam int IDX_W = $clog2(2 * SLOT);
  localparam int SW    = $clog2(W);

  logic [2*W-1:0]    cur;
  logic [W-1:0]      word;
  logic [IDX_W-2:0]  pos;
  logic [SW-1:0]     sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (load_i) cur <= fill_i ? hold_i : '0;
  end

  always_comb begin
    pos   = bit_idx_i[IDX_W-2:0];
    word  = bit_idx_i[IDX_W-1] ? cur[2*W-1:W] : cur[W-1:0];
    sel   = SW'(field_bit(fmt_i, int'(pos), W, SLOT));
    sdo_o = 1'b0;
    if (in_field(fmt_i, int'(pos), W, SLOT)) sdo_o = word[sel];
  end

endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
#(
  parameter int SLOT = 32,
  parameter int W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sample_i,
  input  logic                        last_i,
  input  fmt_e                        fmt_i,
  input  logic [$clog2(2*SLOT)-1:0]   bit_idx_i,
  input  logic                        sdi_i,
  output logic                        valid_o,
  output logic [W-1:0]                left_o,
  output logic [W-1:0]                right_o
);
  localparam int IDX_W = $clog2(2 * SLOT);

  logic [W-1:0]     acc_l, acc_r;
  logic [IDX_W-2:0] pos;
  logic             take;

  assign pos  = bit_idx_i[IDX_W-2:0];
  assign take = sample_i && in_field(fmt_i, int'(pos), W, SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l   <= '0;
      acc_r   <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      if (take) begin
        if (bit_idx_i[IDX_W-1]) acc_r <= {acc_r[W-2:0], sdi_i};
        else                    acc_l <= {acc_l[W-2:0], sdi_i};
      end
      valid_o <= last_i;
      if (last_i) begin
        left_o  <= acc_l;
        right_o <= acc_r;
      end
    end
  end

endmodule

// File: rtl/sap_serial_port.sv
module sap_serial_port
  import sap_pkg::*;
#(
  parameter int DIV   = 16,
  parameter int SLOT  = 32,
  parameter int OUT_W = 20,
  parameter int IN_W  = 16,
  parameter int LANES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_rj,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [LANES*2*OUT_W-1:0]  s_data,
  output logic                      bclk,
  output logic                      ws,
  output logic [LANES-1:0]          sdo,
  input  logic                      sdi,
  output logic                      m_valid,
  output logic [IN_W-1:0]           m_left,
  output logic [IN_W-1:0]           m_right
);
  localparam int IDX_W = $clog2(2 * SLOT);
  localparam int SET_W = LANES * 2 * OUT_W;

  logic [IDX_W-1:0] bit_idx, ws_idx, ws_nxt;
  logic             sample, last;
  logic [SET_W-1:0] hold;
  logic             hold_full;
  logic             accept;
  fmt_e             fmt_q;

  sap_timing #(.DIV(DIV), .SLOT(SLOT)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_o    (bclk),
    .bit_idx_o (bit_idx),
    .ws_idx_o  (ws_idx),
    .sample_o  (sample),
    .last_o    (last)
  );

  assign s_ready = !hold_full;
  assign accept  = s_valid && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      fmt_q     <= FMT_I2S;
    end else begin
      if (last) fmt_q <= fmt_e'(cfg_rj);
      if (accept) begin
        hold      <= s_data;
        hold_full <= 1'b1;
      end else if (last) begin
        hold_full <= 1'b0;
      end
    end
  end

  // I2S: level leads the slot by one bit; right-justified: level tracks slot.
  assign ws_nxt = ws_idx + IDX_W'(1);
  assign ws     = (fmt_q == FMT_I2S) ? ws_nxt[IDX_W-1] : !ws_idx[IDX_W-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sap_tx_lane #(.SLOT(SLOT), .W(OUT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (last),
      .fill_i    (hold_full),
      .hold_i    (hold[g*2*OUT_W +: 2*OUT_W]),
      .fmt_i     (fmt_q),
      .bit_idx_i (bit_idx),
      .sdo_o     (sdo[g])
    );
  end

  sap_rx #(.SLOT(SLOT), .W(IN_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample),
    .last_i    (last),
    .fmt_i     (fmt_q),
    .bit_idx_i (bit_idx),
    .sdi_i     (sdi),
    .valid_o   (m_valid),
    .left_o    (m_left),
    .right_o   (m_right)
  );

endmodule

// File: rtl/sap_serial_port_chk.sv
module sap_serial_port_chk #(
  parameter int DIV   = 16,
  parameter int SLOT  = 32,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk,
  input logic             ws,
  input logic [LANES-1:0] sdo,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid
);
  localparam int HALF  = DIV / 2;
  localparam int FRAME = 2 * SLOT * DIV;
  localparam int RW    = $clog2(DIV) + 1;
  localparam int VW    = $clog2(FRAME) + 2;

  logic          bclk_q;
  logic [RW-1:0] run;
  logic [VW-1:0] vgap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      run    <= '0;
      vgap   <= '0;
    end else begin
      bclk_q <= bclk;
      run    <= (bclk != bclk_q) ? RW'(1) : run + RW'(1);
      vgap   <= m_valid ? VW'(1) : vgap + VW'(1);
    end
  end

  // R2: every bclk level lasts exactly half a bit period
  p_bclk_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != bclk_q) |-> (run == RW'(HALF)));
  p_bclk_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk == bclk_q) |-> (run < RW'(HALF)));

  // R3: data moves with bclk fall, word select with bclk rise
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $fell(bclk));
  p_ws_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $rose(bclk));

  // R7: a transfer closes the holding register
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R10: single-cycle pulse, one per frame
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |=> !m_valid);
  p_valid_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (vgap == VW'(FRAME)));
  p_valid_due_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> (vgap < VW'(FRAME)));

endmodule

bind sap_serial_port sap_serial_port_chk #(
  .DIV   (DIV),
  .SLOT  (SLOT),
  .LANES (LANES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bclk    (bclk),
  .ws      (ws),
  .sdo     (sdo),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .m_valid (m_valid)
);

// File: tb/test_sap_serial_port.sv
module test_sap_serial_port;
  localparam int DIV  = 16;
  localparam int SLOT = 32;
  localparam int BITS = 64;
  localparam int OW   = 20;
  localparam int IW   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rj = 1'b0;
  logic        s_valid = 1'b0;
  logic [79:0] s_data = '0;
  logic        sdi = 1'b0;
  logic        s_ready, bclk, ws, m_valid;
  logic [1:0]  sdo;
  logic [15:0] m_left, m_right;

  always #5 clk = ~clk;

  sap_serial_port i_sap_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_rj(cfg_rj), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .bclk(bclk), .ws(ws), .sdo(sdo), .sdi(sdi),
    .m_valid(m_valid), .m_left(m_left), .m_right(m_right)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Scoreboard queues
  typedef struct { int frame; logic [79:0] d; } txe_t;
  txe_t        txq[$];
  logic [31:0] rxq[$];

  // Slot position -> sample bit, -1 when the position is outside the field
  function automatic int fbit(bit m, int p, int w);
    if (!m) return (p >= 1 && p <= w) ? w - p : -1;
    return (p >= SLOT - w) ? SLOT - 1 - p : -1;
  endfunction

  function automatic bit exp_ws(bit m, int b);
    if (m) return b < SLOT;
    return ((b + 1) % BITS) >= SLOT;
  endfunction

  // Monitor state
  int          rises = 0;
  int          rises_since_v = 0;
  int          per = 0;
  bit          period_bad = 0;
  bit          bclk_prev = 0;
  int          frame_no = 0;
  bit          fmode = 0;
  bit          rx_on = 0;
  bit          rx_act = 0;
  bit          ws_ok = 1;
  bit          last_zero = 0;
  logic [15:0] rxl, rxr;
  logic [BITS-1:0] cap0, cap1;
  logic [OW-1:0]   w0 [2];
  logic [OW-1:0]   w1 [2];

  always @(negedge clk) begin
    if (rst_n) begin
      per++;
      // R10/R9: received words at the start of each frame
      if (m_valid) begin
        chk(rises_since_v == BITS, "R10", "bit clocks between m_valid pulses", rises_since_v, BITS);
        rises_since_v = 0;
        if (rxq.size() > 0) begin
          logic [31:0] e;
          e = rxq.pop_front();
          chk({m_left, m_right} == e, "R9", "received left/right words", {m_left, m_right}, e);
        end
      end
      if (bclk && !bclk_prev) begin
        int b;
        if (rises > 0 && per != DIV) period_bad = 1;
        per = 0;
        b = rises % BITS;
        cap0[b] = sdo[0];
        cap1[b] = sdo[1];
        if (ws !== exp_ws(fmode, b)) ws_ok = 0;
        rises++;
        rises_since_v++;
        if (b == BITS - 1) begin
          bit unused_bad;
          bit allz;
          string lbl;
          logic [79:0] got;
          unused_bad = 0;
          for (int i = 0; i < 2; i++) begin w0[i] = '0; w1[i] = '0; end
          for (int k = 0; k < BITS; k++) begin
            int p, s, q;
            p = k % SLOT; s = k / SLOT; q = fbit(fmode, p, OW);
            if (q < 0) begin
              if (cap0[k] || cap1[k]) unused_bad = 1;
            end else begin
              w0[s][q] = cap0[k];
              w1[s][q] = cap1[k];
            end
          end
          lbl = (cfg_rj != fmode) ? "R11" : (fmode ? "R5" : "R4");
          chk(ws_ok, lbl, "word select pattern in frame", ws_ok, 1);
          chk(!unused_bad, "R6", "unused slot positions zero", unused_bad, 0);
          ws_ok = 1;
          got = {w1[1], w1[0], w0[1], w0[0]};
          allz = (got == '0);
          last_zero = allz;
          if (!allz) begin
            if (txq.size() == 0) chk(0, "R7", "frame without accepted set", got, 0);
            else begin
              txe_t e;
              e = txq.pop_front();
              chk(got == e.d, lbl, "transmitted words", got, e.d);
              chk(frame_no == e.frame, "R7", "frame of transmission", frame_no, e.frame);
            end
          end
        end
      end
      if (!bclk && bclk_prev) begin
        int nb, p, q;
        nb = rises % BITS;
        if (nb == 0) begin
          frame_no++;
          fmode = cfg_rj;
          rx_act = rx_on;
          if (rx_act) begin
            rxl = 16'($urandom);
            rxr = 16'($urandom);
            rxq.push_back({rxl, rxr});
          end
        end
        p = nb % SLOT;
        q = fbit(fmode, p, IW);
        if (!rx_act) sdi = 1'b0;
        else if (q < 0) sdi = 1'b1;
        else sdi = (nb < SLOT) ? rxl[q] : rxr[q];
      end
      bclk_prev = bclk;
    end
  end

  task automatic send(input logic [79:0] d);
    bit r;
    @(negedge clk); #1;
    s_valid = 1'b1;
    s_data  = d;
    while (1) begin
      r = s_ready;
      @(negedge clk); #1;
      if (r) break;
    end
    txq.push_back('{frame_no + 1, d});
    s_valid = 1'b0;
  endtask

  function automatic logic [79:0] rnd_set();
    logic [79:0] v;
    for (int i = 0; i < 4; i++) v[i*20 +: 20] = 20'($urandom) | 20'h00100;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(bclk == 1'b0, "R1", "bclk in reset", bclk, 0);
    chk(ws == 1'b0, "R1", "ws in reset", ws, 0);
    chk(sdo == 2'b00, "R1", "sdo in reset", sdo, 0);
    chk(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
    chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
    #1 rst_n = 1'b1;
    rx_on = 1;
    // I2S frames with corner words: full scale, MSB only, LSB only
    send({20'hFFFFF, 20'h80000, 20'h00001, 20'hFFFFF});
    send({20'h00001, 20'hFFFFF, 20'h80000, 20'h00001});
    send(rnd_set());
    send(rnd_set());
    // R11: switch framing in mid-frame
    do @(negedge clk); while ((rises % BITS) != 40);
    #1 cfg_rj = 1'b1;
    send({20'h80000, 20'h00001, 20'hFFFFF, 20'h80000});
    send(rnd_set());
    send(rnd_set());
    send(rnd_set());
    // R8: stream runs dry
    repeat (3 * 1024) @(negedge clk);
    chk(last_zero, "R8", "silent frame after underflow", last_zero, 1);
    chk(txq.size() == 0, "R7", "sets still waiting", txq.size(), 0);
    // back to I2S, again in mid-frame
    do @(negedge clk); while ((rises % BITS) != 20);
    #1 cfg_rj = 1'b0;
    send(rnd_set());
    send(rnd_set());
    repeat (3 * 1024) @(negedge clk);
    chk(txq.size() == 0, "R7", "sets still waiting at end", txq.size(), 0);
    chk(!period_bad, "R2", "bclk period of 16 core clocks", period_bad, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule